// File: doc/BRIEF.md
# Ping-Pong Piecewise Gamma LUT

This block applies an output transfer curve to each of three colour channels of a pixel stream. Each curve is piecewise linear over 64 equal segments. Every segment point stores a base value and a delta. The top bits of the input choose the point, and the remaining fraction bits scale the delta. The result is saturated to the output width. The block holds two complete curve memories, A and B. Software fills one of them while the other shapes live pixels, then swaps them at a frame boundary.

Loading uses a point index register and a single word-wide data port. Each point takes six consecutive words. A word counter and the point index advance by themselves, so a full curve is one index write followed by a stream of data words. A three-bit mask chooses which colour channels are actually stored. A select bit chooses which memory receives the words. A requested mode (bypass, A or B) is copied into the active status at the next frame-start pulse. The status always names the curve that the pixel path is using. A power-keep input must be high for the memories to accept words and for a curve to be applied.

Top module: `pingpong_gamma_lut`

## Requirements
- R1: After reset the reported status is 0 (bypass), `out_valid` is low, both memories hold zero and the point index and word counter are 0.
- R2: The mode input uses the codes 0 for bypass, 1 for memory A and 2 for memory B. The status changes only on a cycle with `frame_start` high, where it takes the mode code. Mode code 3 gives status 0.
- R3: Each point is loaded as six data-port words in the order red base, green base, blue base, red delta, green delta, blue delta. After the sixth word the point index advances by one. An index write sets the point index and clears the word counter.
- R4: `ram_sel` 0 sends data-port words to memory A, and 1 sends them to memory B.
- R5: Write-mask bit 0 enables red, bit 1 enables green and bit 2 enables blue. A word for a masked-off channel is not stored, but it still advances the word counter.
- R6: A data-port word aimed at the memory that the current status names is ignored.
- R7: With status 1 or 2, each output channel equals min(4095, base + (delta × f) >> 6). The point is the top 6 input bits and f is the low 6 bits. The output appears with `out_valid` two cycles after `pix_valid`.
- R8: With status 0, each output channel equals its input.
- R9: While `pwr_keep` is low, data-port words are not stored, the reported status reads 0 and pixels pass through unchanged. Raising `pwr_keep` again restores the latched status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_keep | input | 1 | Keeps curve memories powered; low gates them |
| mode_in | input | 2 | Requested curve: 0 bypass, 1 A, 2 B |
| frame_start | input | 1 | Frame boundary pulse that applies the mode |
| status_out | output | 2 | Active curve: 0 bypass, 1 A, 2 B |
| idx_wr | input | 1 | Load the point index and clear the word counter |
| idx_val | input | 6 | Point index value |
| ram_sel | input | 1 | Target memory for the data port: 0 A, 1 B |
| wr_mask | input | 3 | Channel write enables (bit 0 red, 1 green, 2 blue) |
| data_wr | input | 1 | Data-port word strobe |
| data_in | input | 12 | Data-port word |
| pix_valid | input | 1 | Input pixel valid |
| pix_r | input | 12 | Red input |
| pix_g | input | 12 | Green input |
| pix_b | input | 12 | Blue input |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 12 | Red output |
| out_g | output | 12 | Green output |
| out_b | output | 12 | Blue output |

## Verification
The bench builds the block with its default parameters: 12-bit input, output and coefficient words, and 64 points, which gives a 6-bit fraction. At this size a complete curve can be loaded in 384 words. This reaches the last point, where the saturation at 4095 happens, and a full ramp where base plus interpolated delta reproduces the input exactly. The equal input and output widths make bypass an identity, which can be compared bit for bit against the curve paths.

// File: rtl/glut_pkg.sv
package glut_pkg;

  typedef enum logic [1:0] {
    SEL_BYP = 2'd0,
    SEL_A   = 2'd1,
    SEL_B   = 2'd2
  } glut_sel_e;

  localparam int unsigned NCH = 3;
  localparam int unsigned WORDS_PER_PT = 6;

  // Mode code to active selection; unknown codes fall back to bypass.
  function automatic glut_sel_e decode_mode(input logic [1:0] code);
    case (code)
      2'd1:    return SEL_A;
      2'd2:    return SEL_B;
      default: return SEL_BYP;
    endcase
  endfunction

endpackage

// File: rtl/glut_wr_seq.sv
module glut_wr_seq #(
  parameter int unsigned PL = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic [PL-1:0] idx_val,
  input  logic          data_wr,
  output logic [2:0]    word_o,
  output logic [PL-1:0] pt_o,
  output logic [1:0]    chan_o,
  output logic          delta_o
);
  import glut_pkg::*;

  localparam logic [2:0] LAST_WORD = 3'(WORDS_PER_PT - 1);

  logic [2:0]    word_q;
  logic [PL-1:0] pt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      pt_q   <= '0;
    end else if (idx_wr) begin
      word_q <= '0;
      pt_q   <= idx_val;
    end else if (data_wr) begin
      if (word_q == LAST_WORD) begin
        word_q <= '0;
        pt_q   <= pt_q + 1'b1;
      end else begin
        word_q <= word_q + 3'd1;
      end
    end
  end

  // Words 0..2 are bases, 3..5 deltas; channel order red, green, blue.
  assign delta_o = (word_q >= 3'd3);
  assign chan_o  = delta_o ? 2'(word_q - 3'd3) : word_q[1:0];
  assign word_o  = word_q;
  assign pt_o    = pt_q;

endmodule

// File: rtl/glut_bank.sv
module glut_bank #(
  parameter int unsigned PL = 6,
  parameter int unsigned CW = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              we,
  input  logic                    is_delta,
  input  logic [PL-1:0]           waddr,
  input  logic [CW-1:0]           wdata,
  input  logic [2:0][PL-1:0]      raddr,
  output logic [2:0][CW-1:0]      rbase,
  output logic [2:0][CW-1:0]      rdelta
);
  localparam int unsigned NPTS = 1 << PL;

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [CW-1:0] base_m  [NPTS];
    logic [CW-1:0] delta_m [NPTS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < NPTS; i++) begin
          base_m[i]  <= '0;
          delta_m[i] <= '0;
        end
      end else if (we[c]) begin
        if (is_delta) delta_m[waddr] <= wdata;
        else          base_m[waddr]  <= wdata;
      end
    end

    assign rbase[c]  = base_m[raddr[c]];
    assign rdelta[c] = delta_m[raddr[c]];
  end

endmodule

// File: rtl/glut_interp.sv
module glut_interp #(
  parameter int unsigned IW = 12,
  parameter int unsigned OW = 12,
  parameter int unsigned CW = 12,
  parameter int unsigned PL = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] pix,
  input  logic          use_curve,
  input  logic [CW-1:0] base,
  input  logic [CW-1:0] delta,
  output logic [OW-1:0] out
);
  localparam int unsigned FW = IW - PL;
  localparam int unsigned SW = ((CW + 1 > OW) ? CW + 1 : OW) + 1;
  localparam logic [SW-1:0] OMAX = SW'((1 << OW) - 1);

  // base + delta * frac / 2^FW, clipped to the output range.
  function automatic logic [OW-1:0] curve_eval(
    input logic [CW-1:0] b,
    input logic [CW-1:0] d,
    input logic [FW-1:0] f
  );
    logic [CW+FW-1:0] prod;
    logic [SW-1:0]    sum;
    prod = (CW+FW)'(d) * (CW+FW)'(f);
    sum  = SW'(b) + SW'(prod >> FW);
    return (sum > OMAX) ? OMAX[OW-1:0] : sum[OW-1:0];
  endfunction

  logic [OW-1:0] byp;
  if (IW >= OW) begin : g_trunc
    assign byp = pix[IW-1 -: OW];
  end else begin : g_pad
    assign byp = {pix, {(OW-IW){1'b0}}};
  end

  logic          s1_curve;
  logic [OW-1:0] s1_byp;
  logic [CW-1:0] s1_base, s1_delta;
  logic [FW-1:0] s1_frac;
  logic [OW-1:0] out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_curve <= 1'b0;
      s1_byp   <= '0;
      s1_base  <= '0;
      s1_delta <= '0;
      s1_frac  <= '0;
      out_q    <= '0;
    end else begin
      s1_curve <= use_curve;
      s1_byp   <= byp;
      s1_base  <= base;
      s1_delta <= delta;
      s1_frac  <= pix[FW-1:0];
      out_q    <= s1_curve ? curve_eval(s1_base, s1_delta, s1_frac) : s1_byp;
    end
  end

  assign out = out_q;

endmodule

// File: rtl/pingpong_gamma_lut.sv
module pingpong_gamma_lut #(
  parameter int unsigned IW = 12,
  parameter int unsigned OW = 12,
  parameter int unsigned CW = 12,
  parameter int unsigned PL = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_keep,
  input  logic [1:0]    mode_in,
  input  logic          frame_start,
  output logic [1:0]    status_out,
  input  logic          idx_wr,
  input  logic [PL-1:0] idx_val,
  input  logic          ram_sel,
  input  logic [2:0]    wr_mask,
  input  logic          data_wr,
  input  logic [CW-1:0] data_in,
  input  logic          pix_valid,
  input  logic [IW-1:0] pix_r,
  input  logic [IW-1:0] pix_g,
  input  logic [IW-1:0] pix_b,
  output logic          out_valid,
  output logic [OW-1:0] out_r,
  output logic [OW-1:0] out_g,
  output logic [OW-1:0] out_b
);
  import glut_pkg::*;

  // Frame-synchronised status; gated to bypass while unpowered.
  glut_sel_e stat_q;
  glut_sel_e active;

  always_ff @(posedge clk) begin
    if (!rst_n)           stat_q <= SEL_BYP;
    else if (frame_start) stat_q <= decode_mode(mode_in);
  end

  assign active     = pwr_keep ? stat_q : SEL_BYP;
  assign status_out = active;

  // Write sequencer.
  logic [2:0]    word_q;
  logic [PL-1:0] wr_pt;
  logic [1:0]    wr_chan;
  logic          wr_delta;

  glut_wr_seq #(.PL(PL)) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_wr  (idx_wr),
    .idx_val (idx_val),
    .data_wr (data_wr && !idx_wr),
    .word_o  (word_q),
    .pt_o    (wr_pt),
    .chan_o  (wr_chan),
    .delta_o (wr_delta)
  );

  logic target_live;
  logic wr_accept;
  assign target_live = ram_sel ? (active == SEL_B) : (active == SEL_A);
  assign wr_accept   = data_wr && !idx_wr && pwr_keep && wr_mask[wr_chan] && !target_live;

  // Pixel lanes, channel 0 red.
  logic [2:0][IW-1:0] pix_a;
  logic [2:0][PL-1:0] rd_pt;
  logic [2:0][OW-1:0] out_a;
  assign pix_a = {pix_b, pix_g, pix_r};

  logic [1:0][2:0][CW-1:0] bk_base, bk_delta;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [2:0] we_b;
    assign we_b = (wr_accept && (ram_sel == b[0])) ? 3'(1 << wr_chan) : 3'b000;

    glut_bank #(.PL(PL), .CW(CW)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (we_b),
      .is_delta (wr_delta),
      .waddr    (wr_pt),
      .wdata    (data_in),
      .raddr    (rd_pt),
      .rbase    (bk_base[b]),
      .rdelta   (bk_delta[b])
    );
  end

  logic use_curve;
  logic sel_b;
  assign use_curve = (active != SEL_BYP);
  assign sel_b     = (active == SEL_B);

  for (genvar c = 0; c < 3; c++) begin : g_lane
    assign rd_pt[c] = pix_a[c][IW-1 -: PL];

    glut_interp #(.IW(IW), .OW(OW), .CW(CW), .PL(PL)) interp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix       (pix_a[c]),
      .use_curve (use_curve),
      .base      (sel_b ? bk_base[1][c]  : bk_base[0][c]),
      .delta     (sel_b ? bk_delta[1][c] : bk_delta[0][c]),
      .out       (out_a[c])
    );
  end

  logic v1_q, v2_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= pix_valid;
      v2_q <= v1_q;
    end
  end

  assign out_valid = v2_q;
  assign out_r     = out_a[0];
  assign out_g     = out_a[1];
  assign out_b     = out_a[2];

endmodule

// File: rtl/glut_chk.sv
module glut_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       pwr_keep,
  input logic [1:0] stat_q,
  input logic [1:0] status_out,
  input logic       wr_accept,
  input logic       ram_sel,
  input logic [2:0] word_q,
  input logic       pix_valid,
  input logic       out_valid
);

  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    status_out != 2'd3); // R2

  AST_STATUS_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(stat_q)); // R2

  AST_LIVE_RAM_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> !((ram_sel == 1'b0 && status_out == 2'd1) ||
                    (ram_sel == 1'b1 && status_out == 2'd2))); // R6

  AST_UNPOWERED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_keep |-> (!wr_accept && status_out == 2'd0)); // R9

  AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    word_q < 3'd6); // R3

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ##2 out_valid); // R7

endmodule

bind pingpong_gamma_lut glut_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .pwr_keep    (pwr_keep),
  .stat_q      (stat_q),
  .status_out  (status_out),
  .wr_accept   (wr_accept),
  .ram_sel     (ram_sel),
  .word_q      (word_q),
  .pix_valid   (pix_valid),
  .out_valid   (out_valid)
);

// File: tb/pingpong_gamma_lut_tb_top.sv
module pingpong_gamma_lut_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_keep = 1'b0;
  logic [1:0]  mode_in = 2'd0;
  logic        frame_start = 1'b0;
  logic [1:0]  status_out;
  logic        idx_wr = 1'b0;
  logic [5:0]  idx_val = '0;
  logic        ram_sel = 1'b0;
  logic [2:0]  wr_mask = 3'b111;
  logic        data_wr = 1'b0;
  logic [11:0] data_in = '0;
  logic        pix_valid = 1'b0;
  logic [11:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic        out_valid;
  logic [11:0] out_r, out_g, out_b;

  always #2 clk = ~clk;

  pingpong_gamma_lut dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_keep(pwr_keep), .mode_in(mode_in),
    .frame_start(frame_start), .status_out(status_out), .idx_wr(idx_wr),
    .idx_val(idx_val), .ram_sel(ram_sel), .wr_mask(wr_mask), .data_wr(data_wr),
    .data_in(data_in), .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g),
    .pix_b(pix_b), .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // Bench model of both memories and of the status.
  int mb [2][3][64];
  int md [2][3][64];
  int lat_st = 0;
  int bptr = 0;
  int bw = 0;

  logic [35:0] exp_q[$];
  string       tag_q[$];

  function automatic int eff_st();
    return pwr_keep ? lat_st : 0;
  endfunction

  function automatic int exp_ch(int ch, int v);
    int bank, p, f, s;
    if (eff_st() == 0) return v;
    bank = (eff_st() == 1) ? 0 : 1;
    p = v / 64;
    f = v % 64;
    s = mb[bank][ch][p] + (md[bank][ch][p] * f) / 64;
    return (s > 4095) ? 4095 : s;
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Driver: push expected item, then present the pixel for one cycle.
  task automatic pix(int r, int g, int b, string tag);
    exp_q.push_back({12'(exp_ch(0, r)), 12'(exp_ch(1, g)), 12'(exp_ch(2, b))});
    tag_q.push_back(tag);
    pix_valid = 1'b1;
    pix_r = 12'(r); pix_g = 12'(g); pix_b = 12'(b);
    tick();
    pix_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (4) tick();
  endtask

  task automatic set_idx(int p);
    idx_wr = 1'b1; idx_val = 6'(p);
    tick();
    idx_wr = 1'b0;
    bptr = p; bw = 0;
  endtask

  task automatic word(int v);
    int ch, live;
    ch = bw % 3;
    live = (eff_st() == 1) ? 0 : (eff_st() == 2) ? 1 : -1;
    if (pwr_keep && wr_mask[ch] && (live != int'(ram_sel))) begin
      if (bw >= 3) md[ram_sel][ch][bptr] = v;
      else         mb[ram_sel][ch][bptr] = v;
    end
    data_wr = 1'b1; data_in = 12'(v);
    tick();
    data_wr = 1'b0;
    if (bw == 5) begin bw = 0; bptr = (bptr + 1) % 64; end
    else bw++;
  endtask

  task automatic point(int rb, int gb, int bb, int rd, int gd, int bd);
    word(rb); word(gb); word(bb); word(rd); word(gd); word(bd);
  endtask

  task automatic frame();
    drain();
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    lat_st = (mode_in == 2'd1) ? 1 : (mode_in == 2'd2) ? 2 : 0;
  endtask

  // Monitor: pop and compare as results appear.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R7 unexpected output actual=%0d expected=none", out_r);
      end else begin
        logic [35:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " red"},   out_r, e[35:24]);
        check({t, " green"}, out_g, e[23:12]);
        check({t, " blue"},  out_b, e[11:0]);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 3; c++)
        for (int p = 0; p < 64; p++) begin mb[b][c][p] = 0; md[b][c][p] = 0; end

    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    @(negedge clk);
    check("R1 status", status_out, 0);
    check("R1 valid", out_valid, 0);
    tick();

    // R8: bypass passes values through.
    pix(0, 0, 0, "R8 zero");
    pix(4095, 1234, 2048, "R8 mix");
    pix(63, 64, 4032, "R8 edge");
    drain();

    // R9: unpowered writes dropped, status reads bypass.
    ram_sel = 1'b0; wr_mask = 3'b111;
    set_idx(40);
    point(999, 999, 999, 999, 999, 999);
    mode_in = 2'd1;
    frame();
    @(negedge clk);
    check("R9 status unpowered", status_out, 0);
    tick();
    pix(40 * 64 + 5, 100, 200, "R9 bypass unpowered");
    drain();
    mode_in = 2'd0;
    frame();

    // Load B (R4, R3) with whole curve.
    pwr_keep = 1'b1;
    ram_sel = 1'b1; wr_mask = 3'b111;
    set_idx(0);
    for (int p = 0; p < 64; p++) point(p * 64, p * 32, 4095 - p * 64, 64, 32, 5);
    set_idx(63);
    point(4090, 2016, 63, 4095, 32, 5);
    mode_in = 2'd2;
    repeat (2) tick();
    @(negedge clk);
    check("R2 status before frame", status_out, 0);
    tick();
    frame();
    @(negedge clk);
    check("R2 status B", status_out, 2);
    tick();
    pix(0, 0, 0, "R7 B zero");
    pix(1000, 1000, 1000, "R7 B ramp");
    pix(2047, 3000, 63, "R7 B mid");
    pix(4095, 4095, 4095, "R7 B saturate");
    drain();

    // R6: writes to live B ignored.
    set_idx(5);
    point(100, 100, 100, 100, 100, 100);
    pix(5 * 64 + 17, 5 * 64 + 40, 5 * 64 + 63, "R6 live ram unchanged");
    drain();

    // R3 partial then index rewrite; R5 mask; R4 target A.
    ram_sel = 1'b0; wr_mask = 3'b101;
    set_idx(20);
    word(2500); word(2600);
    set_idx(0);
    for (int p = 0; p < 8; p++) point(100 + p, 200, 300 + p, 128, 50, 0);
    mode_in = 2'd1;
    frame();
    @(negedge clk);
    check("R4 status A", status_out, 1);
    tick();
    pix(10, 10, 10, "R5 A pt0");
    pix(3 * 64 + 32, 3 * 64 + 32, 7 * 64 + 63, "R5 A mask green");
    pix(20 * 64 + 9, 0, 0, "R3 partial word kept");
    pix(40 * 64 + 5, 0, 0, "R9 dropped write");
    drain();

    // R2: code 3 means bypass.
    mode_in = 2'd3;
    frame();
    @(negedge clk);
    check("R2 status code3", status_out, 0);
    tick();
    pix(777, 888, 999, "R2 code3 bypass");
    drain();

    // R9: power drop and restore.
    mode_in = 2'd2;
    frame();
    pwr_keep = 1'b0;
    @(negedge clk);
    check("R9 status gated", status_out, 0);
    tick();
    pix(1000, 2000, 3000, "R9 gated bypass");
    drain();
    pwr_keep = 1'b1;
    @(negedge clk);
    check("R9 status restored", status_out, 2);
    tick();
    pix(1000, 2000, 3000, "R9 curve restored");
    drain();

    check("R7 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule